// File: doc/BRIEF.md
# Two-Stage Translation Fault Prioritizer

This block sits beside a core's address translation path when a guest runs under a hypervisor. Each access is translated twice: a guest-level first stage maps guest virtual to guest physical, and a host-level second stage maps guest physical to host physical. The second stage also translates the addresses of the first-stage table entries. Any step of that nested walk can flag a fault. The instruction decoder can separately flag an illegal-instruction or virtual-instruction condition. The prioritizer takes all of these flags for one access and selects exactly one exception to report. It returns the cause code, the guest virtual address, and the guest physical address shifted right by two.

Faults are ordered by the walk step that detected them, not by exception type. Page faults and guest page faults therefore share a single class, and their order depends on the step. A request is accepted on a valid/ready handshake. The result is held in a one-entry output register until the consumer takes it.

Top module: `xlate_fault_arb`

## Requirements
- R1: Translation step flags `in_step_flt` are ranked by bit index, and bit 0 is the highest. The step meanings are:
  - bit0: access fault on a second-stage entry read while translating a first-stage table address.
  - bit1: guest page fault while translating the first-stage leaf entry address.
  - bit2: access fault on the first-stage leaf entry.
  - bit3: page fault from checking the first-stage leaf entry.
  - bit4: guest page fault on the second-stage write re-check for a first-stage A/D update.
  - bit5: guest page fault translating the final guest physical address.

  Only the highest set bit is reported.
- R2: For a fetch, a bit0 access fault (cause 1) is reported in preference to a bit3 first-stage page fault (cause 12).
- R3: The cause code depends on the step kind and on `in_acc`. The `in_acc` encoding is 00 fetch, 01 load, 10 store, and 11 is treated as store.
  - Access faults (bits 0 and 2) give 1, 5 or 7.
  - The page fault (bit 3) gives 12, 13 or 15.
  - Guest page faults (bits 1, 4 and 5) give 20, 21 or 23.
- R4: When a fault is taken, `out_gva` takes the request's guest virtual address. `out_gpa_sh` takes the guest physical address shifted right by 2 when the reported cause is a guest page fault, and 0 for any other reported fault.
- R5: On a fetch (`in_acc`=00) with any translation flag set, the decode flags are masked and the translation fault is reported.
- R6: On a load or store, a decode flag outranks every translation flag.
- R7: Decode flags give cause 2 for illegal instruction and cause 22 for virtual instruction. The two share one rank. If both are set, cause 2 is reported.
- R8: When no flag of any kind is set, `out_no_fault` is 1 in the result, and `out_cause`, `out_gva` and `out_gpa_sh` keep their previous values.
- R9: A request is accepted when `in_valid` and `in_ready` are both high. The result appears with `out_valid` one cycle later. `in_ready` equals (not `out_valid`) or `out_ready`. While `out_valid` is high and `out_ready` is low, all result outputs hold.
- R10: After reset, `out_valid` and `out_no_fault` are 0, `out_cause`, `out_gva` and `out_gpa_sh` are 0, and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request can be accepted |
| in_acc | input | 2 | Access type: 00 fetch, 01 load, 10/11 store |
| in_step_flt | input | 6 | Per-walk-step fault flags, bit 0 highest rank |
| in_dec_illegal | input | 1 | Decoder flags illegal instruction |
| in_dec_virtual | input | 1 | Decoder flags virtual instruction |
| in_gva | input | VA_W | Guest virtual address of the access |
| in_gpa | input | GPA_W | Guest physical address of the access |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_no_fault | output | 1 | Accepted request carried no fault |
| out_cause | output | 6 | Reported exception cause |
| out_gva | output | VA_W | Reported guest virtual address |
| out_gpa_sh | output | GPA_W | Reported guest physical address >> 2 |

## Verification
The bench targets cases where a type-based ranking would go wrong:
- A guest page fault at bit1 together with a page fault at bit3 must report the guest fault. A design ranked by type would report cause 12, 13 or 15.
- The A/D re-check guest fault must lose to the leaf page fault.
- Fetch-side masking of decode faults is exercised against the load/store case, where the decode fault must win. A design that got this backwards would report cause 2 on a faulting fetch.
- A no-fault request placed after a guest page fault shows whether the held cause and shifted address were wrongly overwritten.
- A stalled consumer shows whether a new request slips into an unread result.

// File: rtl/xfa_pkg.sv
package xfa_pkg;

  localparam int NSTEP = 6;

  typedef logic [5:0] cause_t;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'b00,
    ACC_LOAD  = 2'b01,
    ACC_STORE = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_e;

  typedef enum logic [1:0] {
    KIND_AF  = 2'd0,
    KIND_PF  = 2'd1,
    KIND_GPF = 2'd2
  } fault_kind_e;

  localparam cause_t CAUSE_ILLEGAL = 6'd2;
  localparam cause_t CAUSE_VIRTUAL = 6'd22;

  // Kind of fault raised at each walk step (index = rank, 0 highest).
  function automatic fault_kind_e step_kind(input int idx);
    case (idx)
      0, 2:    return KIND_AF;
      3:       return KIND_PF;
      default: return KIND_GPF;
    endcase
  endfunction

  // Cause code for a translation fault kind under an access type.
  function automatic cause_t xlate_cause(input fault_kind_e k, input acc_e a);
    cause_t c;
    case (k)
      KIND_AF:  c = (a == ACC_FETCH) ? 6'd1  : (a == ACC_LOAD) ? 6'd5  : 6'd7;
      KIND_PF:  c = (a == ACC_FETCH) ? 6'd12 : (a == ACC_LOAD) ? 6'd13 : 6'd15;
      default:  c = (a == ACC_FETCH) ? 6'd20 : (a == ACC_LOAD) ? 6'd21 : 6'd23;
    endcase
    return c;
  endfunction

  function automatic logic is_guest_cause(input cause_t c);
    return (c == 6'd20) || (c == 6'd21) || (c == 6'd23);
  endfunction

endpackage

// File: rtl/xfa_rank.sv
module xfa_rank #(
  parameter int N = 6
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant,
  output logic         any
);
  // Chain of "a higher step already fired" flags; bit 0 is highest rank.
  logic [N-1:0] blocked;

  assign blocked[0] = 1'b0;
  assign grant[0]   = req[0];

  for (genvar i = 1; i < N; i++) begin : g_chain
    assign blocked[i] = blocked[i-1] | req[i-1];
    assign grant[i]   = req[i] & ~blocked[i];
  end

  assign any = |req;
endmodule

// File: rtl/xfa_cause_sel.sv
module xfa_cause_sel
  import xfa_pkg::*;
(
  input  logic [NSTEP-1:0] grant,
  input  logic             xlate_any,
  input  acc_e             acc,
  input  logic             dec_illegal,
  input  logic             dec_virtual,
  output cause_t           cause,
  output logic             take_fault,
  output logic             gpf_taken,
  output logic             dec_wins
);
  cause_t xl_cause;
  logic   xl_gpf;
  logic   dec_any;
  logic   fetch_xlate;

  always_comb begin
    xl_cause = '0;
    xl_gpf   = 1'b0;
    for (int i = 0; i < NSTEP; i++) begin
      if (grant[i]) begin
        xl_cause = xl_cause | xlate_cause(step_kind(i), acc);
        if (step_kind(i) == KIND_GPF) xl_gpf = 1'b1;
      end
    end
  end

  assign dec_any     = dec_illegal | dec_virtual;
  // A faulting fetch never delivers bits to decode, so decode flags drop.
  assign fetch_xlate = (acc == ACC_FETCH) && xlate_any;
  assign dec_wins    = dec_any && !fetch_xlate;
  assign take_fault  = dec_any | xlate_any;
  assign gpf_taken   = !dec_wins && xl_gpf;
  assign cause       = dec_wins ? (dec_illegal ? CAUSE_ILLEGAL : CAUSE_VIRTUAL)
                                : xl_cause;
endmodule

// File: rtl/xlate_fault_arb.sv
module xlate_fault_arb
  import xfa_pkg::*;
#(
  parameter int VA_W  = 64,
  parameter int GPA_W = 56
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [1:0]       in_acc,
  input  logic [5:0]       in_step_flt,
  input  logic             in_dec_illegal,
  input  logic             in_dec_virtual,
  input  logic [VA_W-1:0]  in_gva,
  input  logic [GPA_W-1:0] in_gpa,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_no_fault,
  output logic [5:0]       out_cause,
  output logic [VA_W-1:0]  out_gva,
  output logic [GPA_W-1:0] out_gpa_sh
);

  function automatic logic [GPA_W-1:0] gpa_report(input logic [GPA_W-1:0] g);
    return g >> 2;
  endfunction

  logic [NSTEP-1:0] step_grant;
  logic             xlate_any;
  cause_t           sel_cause;
  logic             take_fault;
  logic             gpf_taken;
  logic             dec_wins;
  logic             accept;

  xfa_rank #(.N(NSTEP)) u_rank (
    .req   (in_step_flt),
    .grant (step_grant),
    .any   (xlate_any)
  );

  xfa_cause_sel u_sel (
    .grant       (step_grant),
    .xlate_any   (xlate_any),
    .acc         (acc_e'(in_acc)),
    .dec_illegal (in_dec_illegal),
    .dec_virtual (in_dec_virtual),
    .cause       (sel_cause),
    .take_fault  (take_fault),
    .gpf_taken   (gpf_taken),
    .dec_wins    (dec_wins)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_no_fault <= 1'b0;
      out_cause    <= '0;
      out_gva      <= '0;
      out_gpa_sh   <= '0;
    end else if (accept) begin
      out_valid    <= 1'b1;
      out_no_fault <= !take_fault;
      if (take_fault) begin
        out_cause  <= sel_cause;
        out_gva    <= in_gva;
        out_gpa_sh <= gpf_taken ? gpa_report(in_gpa) : '0;
      end
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R1: at most one walk step wins
  a_r1_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(step_grant));

  // R5: a faulting fetch never reports a decode cause
  a_r5_fetch_masks_decode: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (in_acc == 2'b00) && (|in_step_flt)
    |=> !out_no_fault && out_cause != 6'd2 && out_cause != 6'd22);

  // R6: a decode fault on a load/store beats translation
  a_r6_decode_first: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (in_acc != 2'b00) && (in_dec_illegal || in_dec_virtual)
    |=> out_cause == 6'd2 || out_cause == 6'd22);

  // R4: shifted address has cleared top bits, and is zero for non-guest causes
  a_r4_gpa_shift_top: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_no_fault |-> out_gpa_sh[GPA_W-1 -: 2] == 2'b00);

  a_r4_gpa_zero_other: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_no_fault && !is_guest_cause(out_cause) |-> out_gpa_sh == '0);

  // R8: a flag-free request leaves the report registers untouched
  a_r8_no_fault_hold: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !(|in_step_flt) && !in_dec_illegal && !in_dec_virtual
    |=> out_no_fault && $stable(out_cause) && $stable(out_gva) && $stable(out_gpa_sh));

  // R9: stalled result holds
  a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready
    |=> out_valid && $stable(out_cause) && $stable(out_no_fault) && $stable(out_gva));

endmodule

// File: tb/xlate_fault_arb_tb_top.sv
`timescale 1ns/1ps
module xlate_fault_arb_tb_top;
  localparam int VA_W  = 64;
  localparam int GPA_W = 56;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [1:0]       in_acc = '0;
  logic [5:0]       in_step_flt = '0;
  logic             in_dec_illegal = 1'b0;
  logic             in_dec_virtual = 1'b0;
  logic [VA_W-1:0]  in_gva = '0;
  logic [GPA_W-1:0] in_gpa = '0;
  logic             out_valid;
  logic             out_ready = 1'b1;
  logic             out_no_fault;
  logic [5:0]       out_cause;
  logic [VA_W-1:0]  out_gva;
  logic [GPA_W-1:0] out_gpa_sh;

  int checks = 0;
  int errors = 0;

  logic [5:0]       held_cause = '0;
  logic [VA_W-1:0]  held_gva   = '0;
  logic [GPA_W-1:0] held_gpa   = '0;

  always #10 clk = ~clk;

  xlate_fault_arb #(.VA_W(VA_W), .GPA_W(GPA_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_acc(in_acc), .in_step_flt(in_step_flt), .in_dec_illegal(in_dec_illegal),
    .in_dec_virtual(in_dec_virtual), .in_gva(in_gva), .in_gpa(in_gpa),
    .out_valid(out_valid), .out_ready(out_ready), .out_no_fault(out_no_fault),
    .out_cause(out_cause), .out_gva(out_gva), .out_gpa_sh(out_gpa_sh)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Independent model: walk ranking table and cause lookup.
  function automatic void model(input logic [1:0] acc, input logic [5:0] f,
                                input logic ill, input logic virt,
                                output bit take, output logic [5:0] cause,
                                output bit gpf);
    int col;
    int kind; // 0 AF, 1 PF, 2 GPF
    logic [5:0] af_tab [3];
    logic [5:0] pf_tab [3];
    logic [5:0] gf_tab [3];
    af_tab = '{6'd1, 6'd5, 6'd7};
    pf_tab = '{6'd12, 6'd13, 6'd15};
    gf_tab = '{6'd20, 6'd21, 6'd23};
    col  = (acc == 2'b00) ? 0 : (acc == 2'b01) ? 1 : 2;
    take = (f != 0) || ill || virt;
    gpf  = 0;
    cause = '0;
    if ((ill || virt) && !(acc == 2'b00 && f != 0)) begin
      cause = ill ? 6'd2 : 6'd22;
    end else if (f != 0) begin
      kind = 0;
      for (int i = 5; i >= 0; i--) begin
        if (f[i]) kind = (i == 0 || i == 2) ? 0 : (i == 3) ? 1 : 2;
      end
      cause = (kind == 0) ? af_tab[col] : (kind == 1) ? pf_tab[col] : gf_tab[col];
      gpf   = (kind == 2);
    end
  endfunction

  // Drive one request with out_ready high, check the result one cycle later.
  task automatic do_req(input logic [1:0] acc, input logic [5:0] f, input logic ill,
                        input logic virt, input logic [VA_W-1:0] gva,
                        input logic [GPA_W-1:0] gpa, input string req);
    bit take, gpf;
    logic [5:0] ec;
    model(acc, f, ill, virt, take, ec, gpf);
    @(negedge clk);
    in_valid = 1'b1; in_acc = acc; in_step_flt = f;
    in_dec_illegal = ill; in_dec_virtual = virt; in_gva = gva; in_gpa = gpa;
    @(negedge clk);
    in_valid = 1'b0;
    if (take) begin
      held_cause = ec;
      held_gva   = gva;
      held_gpa   = gpf ? (gpa >> 2) : '0;
    end
    chk(out_valid == 1'b1, {req, " R9 valid"}, 64'(out_valid), 64'd1);
    chk(out_no_fault == !take, {req, " R8 no_fault"}, 64'(out_no_fault), 64'(!take));
    chk(out_cause == held_cause, {req, " cause"}, 64'(out_cause), 64'(held_cause));
    chk(out_gva == held_gva, {req, " R4 gva"}, 64'(out_gva), 64'(held_gva));
    chk(out_gpa_sh == held_gpa, {req, " R4 gpa"}, 64'(out_gpa_sh), 64'(held_gpa));
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(out_valid == 0, "R10 out_valid", 64'(out_valid), 0);
    chk(out_no_fault == 0, "R10 out_no_fault", 64'(out_no_fault), 0);
    chk(out_cause == 0, "R10 out_cause", 64'(out_cause), 0);
    chk(out_gpa_sh == 0, "R10 out_gpa_sh", 64'(out_gpa_sh), 0);
    chk(in_ready == 1, "R10 in_ready", 64'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: guest fault at bit1 outranks leaf page fault at bit3
    do_req(2'b01, 6'b001010, 0, 0, 64'h1111, 56'hABCDE4, "R1 gpf_over_pf");
    chk(out_cause == 6'd21, "R1 direct", 64'(out_cause), 21);
    // R1: A/D re-check guest fault loses to leaf page fault
    do_req(2'b10, 6'b110000 | 6'b001000, 0, 0, 64'h2222, 56'h400, "R1 pf_over_ad");
    chk(out_cause == 6'd15, "R1 direct2", 64'(out_cause), 15);
    // R2: fetch, G-stage access fault beats first-stage instruction page fault
    do_req(2'b00, 6'b001001, 0, 0, 64'h3333, 56'h800, "R2 af_over_pf");
    chk(out_cause == 6'd1, "R2 direct", 64'(out_cause), 1);
    // R3: reserved access type acts as store
    do_req(2'b11, 6'b000100, 0, 0, 64'h4444, 56'h0, "R3 rsvd_store");
    chk(out_cause == 6'd7, "R3 direct", 64'(out_cause), 7);
    // R4: final guest fault reports shifted address
    do_req(2'b00, 6'b100000, 0, 0, 64'h5555, 56'hFF_FFFF, "R4 final_gpf");
    chk(out_gpa_sh == 56'h3F_FFFF, "R4 direct", 64'(out_gpa_sh), 64'h3F_FFFF);
    // R8: no fault keeps previous report
    do_req(2'b01, 6'b0, 0, 0, 64'h6666, 56'h123, "R8 none");
    chk(out_cause == 6'd20, "R8 held cause", 64'(out_cause), 20);
    // R5: fetch fault masks illegal instruction
    do_req(2'b00, 6'b000010, 1, 0, 64'h7777, 56'h44, "R5 mask");
    chk(out_cause == 6'd20, "R5 direct", 64'(out_cause), 20);
    // R6: load with virtual-instruction and translation fault
    do_req(2'b01, 6'b000001, 0, 1, 64'h8888, 56'h44, "R6 dec_first");
    chk(out_cause == 6'd22, "R6 direct", 64'(out_cause), 22);
    // R7: both decode flags, illegal reported
    do_req(2'b10, 6'b0, 1, 1, 64'h9999, 56'h0, "R7 both");
    chk(out_cause == 6'd2, "R7 direct", 64'(out_cause), 2);
    // R7: virtual instruction alone on fetch without translation fault
    do_req(2'b00, 6'b0, 0, 1, 64'hAAAA, 56'h0, "R7 virt");

    // R9: stall behaviour
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_acc = 2'b01; in_step_flt = 6'b001000;
    in_dec_illegal = 0; in_dec_virtual = 0; in_gva = 64'hBEEF; in_gpa = 56'h10;
    @(negedge clk);
    chk(out_cause == 6'd13, "R9 first", 64'(out_cause), 13);
    in_acc = 2'b10; in_step_flt = 6'b000100; in_gva = 64'hCAFE;
    chk(in_ready == 0, "R9 in_ready low", 64'(in_ready), 0);
    @(negedge clk);
    chk(out_cause == 6'd13 && out_valid, "R9 hold", 64'(out_cause), 13);
    chk(out_gva == 64'hBEEF, "R9 hold gva", out_gva, 64'hBEEF);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_cause == 6'd7, "R9 second", 64'(out_cause), 7);
    chk(out_gva == 64'hCAFE, "R9 second gva", out_gva, 64'hCAFE);
    held_cause = 6'd7; held_gva = 64'hCAFE; held_gpa = '0;
    @(negedge clk);
    chk(out_valid == 0, "R9 drained", 64'(out_valid), 0);

    // Random mix (R1 R3 R4 R5 R6 R7 R8)
    for (int n = 0; n < 400; n++) begin
      logic [5:0] f;
      logic ill, virt;
      f = 6'($urandom) & 6'($urandom);
      if ($urandom % 4 == 0) f = '0;
      ill  = ($urandom % 5 == 0);
      virt = !ill && ($urandom % 5 == 0);
      do_req(2'($urandom), f, ill, virt, {$urandom, $urandom},
             56'({$urandom, $urandom}), "Rrand");
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule